// File: doc/BRIEF.md
# Serial Flash Power-Down Command Controller

This block is the slave-side command logic of a serial memory on an SPI link in mode 0. A bus master selects it with an active-low chip select and shifts instructions in on SI. The block samples SI on rising SCLK and drives SO on falling SCLK. All pin activity is oversampled by a faster system clock, and every internal delay is a count of that clock.

The controller has four power states: standby, a timed entry into deep power-down, deep power-down, and a timed wake-up. It keeps two status bits. WIP marks a running self-timed program cycle. WEL is the write-enable latch. It also applies a protection level that fences off the upper blocks of the address space against programming. A status-read instruction returns the status byte. A signature instruction returns a fixed 8-bit identifier and, when the device is in deep power-down, also wakes it. The memory array itself is not modelled.

Top module: `spi_pd_ctrl`

## Requirements
- R1: After reset, so, wip, wel and low_pwr are all 0.
- R2: Opcode 0x05 in standby shifts out the byte {3'b000, prot_lvl[2:0], wel, wip}, MSB first. Each bit changes on falling SCLK. The byte repeats for every further 8 SCLK cycles.
- R3: Opcode 0x06 in standby with wip low sets wel.
- R4: A single-byte instruction runs only when CS# rises directly after its eighth bit. Any other bit count discards it.
- R5: Opcode 0xB9 in standby with wip low raises low_pwr exactly T_DP system clocks after the CS# rise is seen. low_pwr stays 0 until then. While wip is high, the opcode is ignored.
- R6: Opcode 0x02 followed by three address bytes and at least one data byte, ending on a byte boundary, is a page program. When wel is 1, wip is 0 and the target is unprotected, wip is held at 1 for T_PP clocks and then drops together with wel. Otherwise nothing changes.
- R7: The block number is address bits 19:16, and there are 16 blocks. Level 0 protects nothing. Levels 1 to 4 protect the top 2^(L-1) blocks. Levels 5 to 7 protect every block. A program aimed at a protected block changes neither wip nor wel.
- R8: During deep power-down, and during the entry and wake-up waits, every opcode other than 0xAB is ignored. wel does not change and SO stays 0.
- R9: Opcode 0xAB issued while a program runs still returns the signature, and it leaves wip and wel untouched.
- R10: In deep power-down, 0xAB ending on a byte boundary keeps low_pwr at 1 for T_RES2 clocks after the CS# rise and then clears it. A misaligned 0xAB leaves the device in deep power-down. In standby, 0xAB causes no power transition.
- R11: Opcode 0xAB shifts out the SIG parameter, MSB first, and repeats it for every further 8 SCLK cycles.
- R12: SO is 0 whenever CS# has been high for several system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| prot_lvl | input | 3 | Block protection level |
| so | output | 1 | Serial data out |
| wip | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable latch |
| low_pwr | output | 1 | Device is in deep power-down or waking from it |

## Verification
If the power-state machine sits in the wrong state, the fault shows up in the first status read or signature read afterwards. A stuck low-power state makes SO read as all zeros. A missed wake-up leaves low_pwr high past the T_RES2 window. A corrupted bit or byte counter shows up in a single transaction: a misaligned opcode executes, or an aligned one is dropped, and WEL or low_pwr then has the wrong value within a few clocks of the CS# rise. A wrong program timer or protection decode shows as WIP held for the wrong number of cycles, or as WIP rising on a protected block, and is visible one status read later.

// File: rtl/spi_pd_ctrl.sv
module spi_pd_ctrl #(
  parameter int          T_DP    = 400,
  parameter int          T_RES2  = 400,
  parameter int          T_PP    = 1000,
  parameter logic [7:0]  SIG     = 8'h13,
  parameter int          BLK_W   = 4,
  parameter int          BLK_LSB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       si,
  input  logic [2:0] prot_lvl,
  output logic       so,
  output logic       wip,
  output logic       wel,
  output logic       low_pwr
);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SLP  = 8'hB9;
  localparam logic [7:0] OP_WAKE = 8'hAB;
  localparam int TMAX  = (T_DP > T_RES2) ? ((T_DP > T_PP) ? T_DP : T_PP)
                                         : ((T_RES2 > T_PP) ? T_RES2 : T_PP);
  localparam int TW    = $clog2(TMAX + 1);
  localparam int AW    = BLK_LSB + BLK_W;
  localparam int NBLK  = 1 << BLK_W;

  typedef enum logic [1:0] {S_STBY, S_ENTER, S_DPD, S_WAKE} pstate_t;

  logic [2:0] sclk_p, cs_p;
  logic [1:0] si_p;
  logic       sclk_r, sclk_f, cs_fall, cs_rise, sel, si_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      si_p   <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      si_p   <= {si_p[0], si};
    end

  assign sclk_r  = sclk_p[1] & ~sclk_p[2];
  assign sclk_f  = ~sclk_p[1] & sclk_p[2];
  assign cs_fall = ~cs_p[1] & cs_p[2];
  assign cs_rise = cs_p[1] & ~cs_p[2];
  assign sel     = ~cs_p[1];
  assign si_s    = si_p[1];

  logic [2:0]    idx, nbytes;
  logic [7:0]    op;
  logic [AW-1:0] addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx    <= '0;
      nbytes <= '0;
      op     <= '0;
      addr   <= '0;
    end else if (cs_fall) begin
      idx    <= '0;
      nbytes <= '0;
    end else if (sel && sclk_r) begin
      idx <= idx + 3'd1;
      if (idx == 3'd7 && nbytes != 3'd7) nbytes <= nbytes + 3'd1;
      if (nbytes == 3'd0) op <= {op[6:0], si_s};
      if (nbytes >= 3'd1 && nbytes <= 3'd3) addr <= {addr[AW-2:0], si_s};
    end

  pstate_t       st;
  logic [TW-1:0] ptmr, wtmr;
  logic          entering;

  logic [BLK_W:0] nprot;
  logic [BLK_W:0] blk;
  logic           blk_prot;

  always_comb begin
    if (prot_lvl == 3'd0)                 nprot = '0;
    else if (int'(prot_lvl) > BLK_W)      nprot = (BLK_W+1)'(NBLK);
    else                                  nprot = (BLK_W+1)'(1) << (prot_lvl - 3'd1);
    blk      = {1'b0, addr[BLK_LSB +: BLK_W]};
    blk_prot = (nprot != '0) && (blk >= (BLK_W+1)'(NBLK) - nprot);
  end

  logic aligned, one_byte, idle_ok;
  logic do_wren, do_slp, do_prog, do_wake;

  assign aligned  = (idx == 3'd0);
  assign one_byte = aligned && (nbytes == 3'd1);
  assign idle_ok  = cs_rise && (st == S_STBY) && !wip;
  assign do_wren  = idle_ok && one_byte && (op == OP_WREN);
  assign do_slp   = idle_ok && one_byte && (op == OP_SLP);
  assign do_prog  = idle_ok && wel && aligned && (nbytes >= 3'd5) &&
                    (op == OP_PROG) && !blk_prot;
  assign do_wake  = cs_rise && (st == S_DPD) && aligned && (nbytes != 3'd0) &&
                    (op == OP_WAKE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_STBY;
      ptmr <= '0;
    end else begin
      case (st)
        S_STBY:  if (do_slp) begin
                   st   <= S_ENTER;
                   ptmr <= TW'(T_DP - 1);
                 end
        S_ENTER: if (ptmr == '0) st <= S_DPD;
                 else ptmr <= ptmr - 1'b1;
        S_DPD:   if (do_wake) begin
                   st   <= S_WAKE;
                   ptmr <= TW'(T_RES2 - 1);
                 end
        default: if (ptmr == '0) st <= S_STBY;
                 else ptmr <= ptmr - 1'b1;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wip  <= 1'b0;
      wel  <= 1'b0;
      wtmr <= '0;
    end else if (wip) begin
      if (wtmr == '0) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end else wtmr <= wtmr - 1'b1;
    end else if (do_prog) begin
      wip  <= 1'b1;
      wtmr <= TW'(T_PP - 1);
    end else if (do_wren) wel <= 1'b1;

  logic       rd_en;
  logic [7:0] rd_val;

  assign rd_en  = (nbytes != 3'd0) &&
                  (((op == OP_RDSR) && (st == S_STBY)) ||
                   ((op == OP_WAKE) && ((st == S_STBY) || (st == S_DPD))));
  assign rd_val = (op == OP_RDSR) ? {3'b000, prot_lvl, wel, wip} : SIG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              so <= 1'b0;
    else if (!sel)           so <= 1'b0;
    else if (sclk_f)         so <= rd_en ? rd_val[~idx] : 1'b0;

  assign low_pwr  = (st == S_DPD) || (st == S_WAKE);
  assign entering = (st == S_ENTER);
endmodule

module spi_pd_ctrl_chk #(
  parameter int T_DP = 400
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so,
  input logic wip,
  input logic wel,
  input logic low_pwr,
  input logic entering
);
  logic [31:0] ecnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ecnt <= '0;
    else if (entering) ecnt <= ecnt + 1;
    else               ecnt <= '0;

  // R12
  so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !so);

  // R6
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> wel);

  // R6
  prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  // R5
  entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= T_DP);

  // R5
  sleep_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_pwr) |-> $past(entering));

  // R8
  wel_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !low_pwr && !entering);

  // R9
  busy_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wip && low_pwr));
endmodule

bind spi_pd_ctrl spi_pd_ctrl_chk #(.T_DP(T_DP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .wip(wip),
  .wel(wel), .low_pwr(low_pwr), .entering(entering)
);

// File: tb/tb_spi_pd_ctrl.sv
module tb_spi_pd_ctrl;
  localparam int CLK    = 10;
  localparam int HALF   = 8;
  localparam int T_DP   = 400;
  localparam int T_RES2 = 400;
  localparam int T_PP   = 1000;
  localparam logic [7:0] SIG = 8'h13;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic [2:0] prot_lvl = 3'd0;
  logic so, wip, wel, low_pwr;
  int vecs = 0, fails = 0;

  always #(CLK/2) clk = ~clk;

  spi_pd_ctrl #(.T_DP(T_DP), .T_RES2(T_RES2), .T_PP(T_PP), .SIG(SIG)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .prot_lvl(prot_lvl), .so(so), .wip(wip), .wel(wel), .low_pwr(low_pwr));

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic w, input logic e, input logic [2:0] l);
    return {3'b000, l, e, w};
  endfunction

  function automatic logic exp_prot(input logic [2:0] l, input int b);
    int n;
    if (l == 0) return 1'b0;
    n = (l > 4) ? 16 : (1 << (l - 1));
    return b >= 16 - n;
  endfunction

  task automatic wt(input int n); #(n*CLK); endtask
  task automatic sbit(input logic b);
    si = b; wt(HALF); sclk = 1'b1; wt(HALF); sclk = 1'b0;
  endtask
  task automatic sbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
  endtask
  task automatic rbyte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wt(HALF); b[i] = so; sclk = 1'b1; wt(HALF); sclk = 1'b0;
    end
  endtask
  task automatic start(); cs_n = 1'b0; wt(HALF); endtask
  task automatic stop(); wt(HALF); cs_n = 1'b1; wt(10); endtask
  task automatic cmd1(input logic [7:0] op); start(); sbyte(op); stop(); endtask
  task automatic rd_status(output logic [7:0] s);
    start(); sbyte(8'h05); rbyte(s); stop();
  endtask
  task automatic prog(input int blk);
    start(); sbyte(8'h02); sbyte(8'(blk)); sbyte(8'h12); sbyte(8'h34); sbyte(8'hA5); stop();
  endtask

  initial begin
    wt(190000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [7:0] s, s2;
    logic ew;
    void'($urandom(32'd11));
    wt(5); rst_n = 1'b1; wt(5);
    // R1
    check("R1 so", so, 0); check("R1 wip", wip, 0);
    check("R1 wel", wel, 0); check("R1 low_pwr", low_pwr, 0);
    rd_status(s); check("R2 status after reset", s, exp_status(0, 0, 0));
    prot_lvl = 3'd5;
    start(); sbyte(8'h05); rbyte(s); rbyte(s2); stop();
    check("R2 status level", s, exp_status(0, 0, 5));
    check("R2 status repeat", s2, exp_status(0, 0, 5));
    prot_lvl = 3'd0;
    // R4 misaligned write enable
    start(); sbyte(8'h06); sbit(1'b0); stop();
    rd_status(s); check("R4 nine bits discarded", s, exp_status(0, 0, 0));
    start(); for (int i = 7; i >= 1; i--) sbit(OP_BIT(i)); stop();
    rd_status(s); check("R4 seven bits discarded", s, exp_status(0, 0, 0));
    prog(1); check("R6 program without wel", wip, 0);
    cmd1(8'h06); rd_status(s); check("R3 wel set", s, exp_status(0, 1, 0));
    prot_lvl = 3'd3;
    prog(13); check("R7 protected wip", wip, 0); check("R7 protected wel", wel, 1);
    prog(11); check("R6 program starts", wip, 1);
    rd_status(s); check("R2 status busy", s, exp_status(1, 1, 3));
    start(); sbyte(8'hAB); rbyte(s); stop();
    check("R9 signature while busy", s, SIG);
    check("R9 wip kept", wip, 1); check("R9 wel kept", wel, 1);
    cmd1(8'hB9); wt(T_DP + 40); check("R5 sleep ignored while busy", low_pwr, 0);
    wt(T_PP); check("R6 wip done", wip, 0); check("R6 wel cleared", wel, 0);
    cmd1(8'h06); prog(0);
    wt(T_PP - 40); check("R6 wip held", wip, 1);
    wt(60); check("R6 wip released", wip, 0);
    prot_lvl = 3'd0;
    // R5 / R8 entry into deep power-down
    cmd1(8'hB9); check("R5 not yet asleep", low_pwr, 0);
    cmd1(8'h06); check("R5 still entering", low_pwr, 0);
    wt(T_DP); check("R5 asleep", low_pwr, 1);
    rd_status(s); check("R8 status ignored", s, 0);
    cmd1(8'h06);
    start(); sbyte(8'hAB); sbit(1'b1); stop();
    wt(T_RES2 + 40); check("R10 misaligned wake", low_pwr, 1);
    start(); sbyte(8'hAB); rbyte(s); rbyte(s2); stop();
    check("R11 signature", s, SIG); check("R11 signature repeat", s2, SIG);
    check("R10 waking", low_pwr, 1);
    wt(T_RES2 - 40); check("R10 still waking", low_pwr, 1);
    wt(60); check("R10 awake", low_pwr, 0);
    rd_status(s); check("R8 wel untouched", s, exp_status(0, 0, 0));
    start(); sbyte(8'hAB); rbyte(s); stop();
    check("R11 signature standby", s, SIG); check("R10 standby no change", low_pwr, 0);
    // R7 random protection sweep
    for (int k = 0; k < 14; k++) begin
      int b;
      prot_lvl = 3'($urandom % 8);
      b = int'($urandom % 16);
      cmd1(8'h06); prog(b);
      ew = !exp_prot(prot_lvl, b);
      check("R7 random wip", wip, ew);
      rd_status(s); check("R7 random status", s, exp_status(ew, 1, prot_lvl));
      wt(T_PP);
      check("R6 random wel", wel, !ew); check("R6 random wip end", wip, 0);
      if (!ew) begin cmd1(8'h06); prot_lvl = 3'd0; prog(2); wt(T_PP); end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  function automatic logic OP_BIT(input int i);
    logic [7:0] w = 8'h06;
    return w[i];
  endfunction
endmodule